// File: doc/BRIEF.md
# Pausable Clock Port Controller for a Locally Synchronous Island

This block sits beside one locally synchronous island in a design whose islands talk to each other asynchronously. It decides when the island's local clock may tick. The island's clock starts when the island is called into work. The clock is held off for the whole of every outgoing data transfer. The clock is locked off for good once the island reports that its task is finished.

The local clock is the external clock ANDed with an enable. The enable register updates only on the falling edge of the external clock, so a local pulse is always a full pulse or nothing. Each outgoing word is sent over a four-phase request/acknowledge port. The controller latches the island's word, raises the request one cycle later, and drops the request once the acknowledge is seen high. It lets the island clock run again only after the acknowledge has returned low.

The reset input is asynchronous and active-low. Its release is synchronised to the external clock inside the block.

Top module: `island_clk_port_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no activation, `clk_en_o`, `local_clk_o` and `port_req_o` are 0 and `port_data_o` is all zeros. Asserting reset clears `clk_en_o` and `port_req_o` at once, without waiting for a clock edge.
- R2: When `activate_i` is high in the idle state, `clk_en_o` is 1 from the following falling edge of the external clock. From then on `local_clk_o` produces one full pulse per external cycle until the clock is paused or locked.
- R3: When `island_send_i` is high while running and `island_done_i` is low, `island_data_i` is latched onto `port_data_o` at that edge. `clk_en_o` falls at the next falling edge, so the island receives no further pulses.
- R4: `port_req_o` rises one external cycle after the word is latched. It stays high for as long as `port_ack_i` is low.
- R5: `port_req_o` falls at the first edge after `port_ack_i` is seen high. The clock stays stopped while `port_ack_i` remains high. `clk_en_o` returns to 1 only after `port_ack_i` is seen low.
- R6: `port_data_o` does not change from the latch edge until the next word is accepted, whatever `island_data_i` does in between.
- R7: `island_done_i` high while running locks the clock off (`clk_en_o` 0 from the next falling edge). It takes priority over a simultaneous `island_send_i`, so no word is latched. The lock holds while `activate_i` stays high. A fresh rise of `activate_i` after it has gone low restarts the clock.
- R8: `clk_en_o` changes only while the external clock is low.
- R9: `port_ack_i` has no effect outside a transfer. While running, a high `port_ack_i` leaves `clk_en_o` at 1 and `port_req_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ext_i | input | 1 | External (free-running) clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| activate_i | input | 1 | Level request to run the island |
| island_done_i | input | 1 | Island reports its task finished |
| island_send_i | input | 1 | Island offers a word for transfer |
| island_data_i | input | DATA_W | Word offered by the island |
| port_ack_i | input | 1 | Four-phase acknowledge from the receiver |
| port_req_o | output | 1 | Four-phase request to the receiver |
| port_data_o | output | DATA_W | Word held on the port |
| clk_en_o | output | 1 | Enable gating the local clock |
| local_clk_o | output | 1 | External clock ANDed with the enable |

## Verification
The bench targets four corner cases.

- **Acknowledge already high when the request rises.** A controller that resumes on the acknowledge edge rather than its return to low would tick the island mid-handshake.
- **Long acknowledge wait.** A controller that does not hold the request would abandon the handshake early.
- **Done and send arriving together.** A controller that ranks send first would latch a stray word and open a transfer after the task ended.
- **Stray acknowledge while running, and reset while the clock runs.** Local pulses are counted across every pause, so a single leaked pulse or a truncated pulse from an enable updated on the rising edge shows up as a count mismatch.

// File: rtl/hsk_pkg.sv
package hsk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_HS_REQ,
    ST_HS_WAIT_ACK_LOW,
    ST_DONE
  } hsk_state_e;
endpackage

// File: rtl/hsk_rst_sync.sv
module hsk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/hsk_fsm.sv
module hsk_fsm
  import hsk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic activate_i,
  input  logic done_i,
  input  logic send_i,
  input  logic ack_i,
  output logic run_o,
  output logic load_o,
  output logic req_o
);
  hsk_state_e state_q, state_d;
  logic       req_q, req_d;

  always_comb begin
    state_d = state_q;
    req_d   = req_q;
    load_o  = 1'b0;
    case (state_q)
      ST_IDLE: if (activate_i) state_d = ST_RUN;
      ST_RUN: begin
        if (done_i) begin
          state_d = ST_DONE;
        end else if (send_i) begin
          state_d = ST_HS_REQ;
          load_o  = 1'b1;
        end
      end
      ST_HS_REQ: begin
        if (!req_q) begin
          req_d = 1'b1;
        end else if (ack_i) begin
          req_d   = 1'b0;
          state_d = ST_HS_WAIT_ACK_LOW;
        end
      end
      ST_HS_WAIT_ACK_LOW: if (!ack_i) state_d = ST_RUN;
      ST_DONE: if (!activate_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= ST_IDLE;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
    end
  end

  assign run_o = (state_q == ST_RUN);
  assign req_o = req_q;
endmodule

// File: rtl/hsk_clk_gate.sv
module hsk_clk_gate (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic run_i,
  output logic en_o,
  output logic gclk_o
);
  logic en_q;

  always_ff @(negedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) en_q <= 1'b0;
    else          en_q <= run_i;
  end

  assign en_o   = en_q;
  assign gclk_o = clk_i & en_q;
endmodule

// File: rtl/hsk_data_hold.sv
module hsk_data_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)    data_q <= '0;
    else if (load_i) data_q <= data_i;
  end

  assign data_o = data_q;
endmodule

// File: rtl/island_clk_port_ctrl.sv
module island_clk_port_ctrl #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned RST_SYNCS = 2
) (
  input  logic              clk_ext_i,
  input  logic              rst_n_i,
  input  logic              activate_i,
  input  logic              island_done_i,
  input  logic              island_send_i,
  input  logic [DATA_W-1:0] island_data_i,
  input  logic              port_ack_i,
  output logic              port_req_o,
  output logic [DATA_W-1:0] port_data_o,
  output logic              clk_en_o,
  output logic              local_clk_o
);
  logic rst_n_sync;
  logic run;
  logic load;

  hsk_rst_sync #(.STAGES(RST_SYNCS)) u_rst (
    .clk_i   (clk_ext_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_n_sync)
  );

  hsk_fsm u_fsm (
    .clk_i      (clk_ext_i),
    .rst_n_i    (rst_n_sync),
    .activate_i (activate_i),
    .done_i     (island_done_i),
    .send_i     (island_send_i),
    .ack_i      (port_ack_i),
    .run_o      (run),
    .load_o     (load),
    .req_o      (port_req_o)
  );

  hsk_data_hold #(.DATA_W(DATA_W)) u_data (
    .clk_i   (clk_ext_i),
    .rst_n_i (rst_n_sync),
    .load_i  (load),
    .data_i  (island_data_i),
    .data_o  (port_data_o)
  );

  hsk_clk_gate u_gate (
    .clk_i   (clk_ext_i),
    .rst_n_i (rst_n_sync),
    .run_i   (run),
    .en_o    (clk_en_o),
    .gclk_o  (local_clk_o)
  );
endmodule

// File: rtl/island_clk_port_ctrl_chk.sv
module island_clk_port_ctrl_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_ext_i,
  input logic              rst_n_i,
  input logic              island_done_i,
  input logic              port_ack_i,
  input logic              port_req_o,
  input logic [DATA_W-1:0] port_data_o,
  input logic              clk_en_o
);
  // R8
  always @(clk_en_o) begin
    if (rst_n_i === 1'b1)
      en_change_low_chk: assert (clk_ext_i === 1'b0);
  end

  // R4
  req_hold_chk: assert property (@(posedge clk_ext_i) disable iff (!rst_n_i)
    (port_req_o && !port_ack_i) |=> port_req_o);

  // R5
  req_drop_chk: assert property (@(posedge clk_ext_i) disable iff (!rst_n_i)
    (port_req_o && port_ack_i) |=> !port_req_o);

  // R6
  data_stable_chk: assert property (@(posedge clk_ext_i) disable iff (!rst_n_i)
    port_req_o |-> $stable(port_data_o));

  // R3
  en_off_in_hs_chk: assert property (@(posedge clk_ext_i) disable iff (!rst_n_i)
    port_req_o |-> !clk_en_o);

  // R7
  done_lock_chk: assert property (@(posedge clk_ext_i) disable iff (!rst_n_i)
    (clk_en_o && island_done_i) |=> !clk_en_o);
endmodule

bind island_clk_port_ctrl island_clk_port_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_ext_i     (clk_ext_i),
  .rst_n_i       (rst_n_i),
  .island_done_i (island_done_i),
  .port_ack_i    (port_ack_i),
  .port_req_o    (port_req_o),
  .port_data_o   (port_data_o),
  .clk_en_o      (clk_en_o)
);

// File: tb/island_clk_port_ctrl_tb_top.sv
module island_clk_port_ctrl_tb_top;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          act, done, send, ack;
  logic [DW-1:0] din;
  logic          req, en, lclk;
  logic [DW-1:0] dout;
  int            n_chk = 0;
  int            n_fail = 0;
  int            pulses = 0;

  always #2 clk = ~clk;  // 250 MHz

  island_clk_port_ctrl #(.DATA_W(DW)) dut_i (
    .clk_ext_i     (clk),
    .rst_n_i       (rst_n),
    .activate_i    (act),
    .island_done_i (done),
    .island_send_i (send),
    .island_data_i (din),
    .port_ack_i    (ack),
    .port_req_o    (req),
    .port_data_o   (dout),
    .clk_en_o      (en),
    .local_clk_o   (lclk)
  );

  always @(posedge lclk) pulses++;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // {act, done, send, ack, din, exp_en, exp_req, exp_dout}
  localparam int NV = 20;
  localparam logic [21:0] VEC [NV] = '{
    {4'b1000, 8'h00, 2'b10, 8'h00},  // R2 activate
    {4'b1000, 8'h00, 2'b10, 8'h00},  // R2 running
    {4'b1010, 8'hA5, 2'b00, 8'hA5},  // R3 latch, clock stops
    {4'b1000, 8'h11, 2'b01, 8'hA5},  // R4 req one cycle later, R6
    {4'b1001, 8'h22, 2'b00, 8'hA5},  // R5 req drops on ack
    {4'b1001, 8'h33, 2'b00, 8'hA5},  // R5 still stopped while ack high
    {4'b1000, 8'h44, 2'b10, 8'hA5},  // R5 resume after ack low
    {4'b1010, 8'h3C, 2'b00, 8'h3C},  // R3 second word
    {4'b1000, 8'h00, 2'b01, 8'h3C},  // R4 req raised
    {4'b1000, 8'hFF, 2'b01, 8'h3C},  // R4 req held while waiting
    {4'b1001, 8'h00, 2'b00, 8'h3C},  // R5 drop
    {4'b1000, 8'h00, 2'b10, 8'h3C},  // R5 resume
    {4'b1110, 8'h77, 2'b00, 8'h3C},  // R7 done beats send
    {4'b1000, 8'h00, 2'b00, 8'h3C},  // R7 locked while act high
    {4'b0000, 8'h00, 2'b00, 8'h3C},  // R7 act withdrawn
    {4'b0000, 8'h00, 2'b00, 8'h3C},  // R7 idle
    {4'b1000, 8'h00, 2'b10, 8'h3C},  // R7 re-activation restarts
    {4'b1001, 8'h00, 2'b10, 8'h3C},  // R9 stray ack ignored
    {4'b1100, 8'h00, 2'b00, 8'h3C},  // R7 done
    {4'b0000, 8'h00, 2'b00, 8'h3C}   // back to idle
  };

  initial begin
    #200000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; act = 0; done = 0; send = 0; ack = 0; din = '0;
    repeat (3) @(posedge clk);
    #3;
    chk("R1 en in reset", {31'b0, en}, 0);
    chk("R1 req in reset", {31'b0, req}, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #3;
    chk("R1 en idle", {31'b0, en}, 0);
    chk("R1 lclk idle", {31'b0, lclk}, 0);
    chk("R1 data idle", {24'b0, dout}, 0);

    for (int i = 0; i < NV; i++) begin
      {act, done, send, ack} = VEC[i][21:18];
      din = VEC[i][17:10];
      @(posedge clk);
      #3;
      chk($sformatf("R2/R3/R5/R7/R9 vec %0d en", i), {31'b0, en}, {31'b0, VEC[i][9]});
      chk($sformatf("R4/R5 vec %0d req", i), {31'b0, req}, {31'b0, VEC[i][8]});
      chk($sformatf("R6 vec %0d data", i), {24'b0, dout}, {24'b0, VEC[i][7:0]});
    end

    // R2: one full pulse per cycle while running
    act = 1; done = 0; send = 0; ack = 0;
    @(posedge clk); #3;
    pulses = 0;
    repeat (5) @(posedge clk);
    #3;
    chk("R2 pulse count", pulses, 5);

    // R3/R5: no pulses through a handshake with a long wait
    send = 1; din = 8'h5A;
    @(posedge clk); #3;
    send = 0;
    chk("R3 data latched", {24'b0, dout}, 32'h5A);
    pulses = 0;
    repeat (6) @(posedge clk);
    #3;
    chk("R4 req held in long wait", {31'b0, req}, 1);
    ack = 1;
    repeat (3) @(posedge clk);
    #3;
    chk("R5 req low with ack high", {31'b0, req}, 0);
    ack = 0;
    @(posedge clk); #3;
    chk("R5 no pulses during handshake", pulses, 0);
    chk("R5 en back after ack low", {31'b0, en}, 1);

    // R1: asynchronous reset while clock runs
    rst_n = 1'b0;
    #0.5;
    chk("R1 async en clear", {31'b0, en}, 0);
    chk("R1 async lclk clear", {31'b0, lclk}, 0);
    act = 0;
    @(posedge clk); #3;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #3;
    chk("R1 data cleared", {24'b0, dout}, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule